// File: doc/BRIEF.md
# Invalidation Completion Event Controller

This block turns completion notices from an invalidation queue processor into message-signalled interrupt requests. When a wait descriptor finishes, the queue processor sends a one-cycle completion pulse. The block records the completion in a sticky status bit. It then either issues an interrupt at once or, if software has masked the event, keeps the event as pending.

Software works through four registers. The completion status register clears on a write of 1. The event control register has one writable mask bit and a read-only pending bit. Two plain registers hold the message data and the message address. When a masked event is pending and software clears the mask, the held event is replayed. While the status bit is still set, any further completion pulse is ignored. An issued request is a one-cycle valid pulse that carries the programmed data and address words. A separate fabric delivers the message.

Top module: `inv_evt_ctrl`

## Requirements
- R1: After reset the status bit (status register bit 0) and the pending bit (control register bit 30) read 0, the mask bit (control register bit 31) reads 1, the data and address registers read 0, and no request is issued.
- R2: A completion pulse that arrives while the status bit is already set changes no register and issues no request.
- R3: A completion pulse that arrives while the status bit is clear and the mask is 0 sets the status bit, leaves pending at 0, and raises `irq_valid_o` for exactly the one cycle after the pulse's clock edge.
- R4: A completion pulse that arrives while the status bit is clear and the mask is 1 sets both the status bit and the pending bit, and issues no request.
- R5: A status write with bit 0 = 1 clears both the status bit and the pending bit. A status write with bit 0 = 0 has no effect.
- R6: In the control register only bit 31 (mask) is writable. Writing 1 there sets the mask. Every other control bit, pending included, ignores writes, and bits other than 31 and 30 read 0.
- R7: A control write with bit 31 = 0 while pending is set clears the mask and the pending bit, and issues one request in the next cycle.
- R8: A control write with bit 31 = 0 while pending is clear clears the mask and issues no request.
- R9: A request carries the data and address register values from the cycle in which the event was accepted. A data or address write in that same cycle affects only later requests.
- R10: Within one cycle, a status write takes effect first, then a control write, then the completion pulse, which sees the result of the writes.
- R11: The data and address registers read back the last value written to each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Completion pulse from the queue processor |
| sts_wr_i | input | 1 | Write strobe, completion status register |
| sts_wdata_i | input | 32 | Write data, completion status register |
| ctl_wr_i | input | 1 | Write strobe, event control register |
| ctl_wdata_i | input | 32 | Write data, event control register |
| data_wr_i | input | 1 | Write strobe, message data register |
| data_wdata_i | input | 32 | Write data, message data register |
| addr_wr_i | input | 1 | Write strobe, message address register |
| addr_wdata_i | input | 32 | Write data, message address register |
| sts_o | output | 32 | Completion status register readback |
| ctl_o | output | 32 | Event control register readback |
| data_o | output | 32 | Message data register readback |
| addr_o | output | 32 | Message address register readback |
| irq_valid_o | output | 1 | One-cycle interrupt request |
| irq_data_o | output | 32 | Message data carried by the request |
| irq_addr_o | output | 32 | Message address carried by the request |

## Verification
The bench builds the block with its default parameters: 32-bit data and address words, status at bit 0, mask at bit 31 and pending at bit 30. These settings expose the exact bit positions that software would decode. Random traffic often lines up completion pulses with status clears, mask changes and payload writes in the same cycle. This reaches the ordering of R10 and the payload sampling of R9 more often than directed cases alone could.

// File: rtl/inv_evt_pkg.sv
package inv_evt_pkg;

    typedef struct packed {
        logic done_seen;
        logic masked;
        logic held;
    } evt_flags_t;

endpackage

// File: rtl/inv_evt_flags.sv
module inv_evt_flags
    import inv_evt_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int STS_BIT  = 0,
    parameter int MASK_BIT = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             sts_wr_i,
    input  logic [REG_W-1:0] sts_wdata_i,
    input  logic             ctl_wr_i,
    input  logic [REG_W-1:0] ctl_wdata_i,
    output evt_flags_t       flags_o,
    output logic             fire_o
);

    evt_flags_t flags_d, flags_q;
    logic       fire_d;

    // Order inside a cycle: status clear, then mask write, then completion pulse.
    always_comb begin
        flags_d = flags_q;
        fire_d  = 1'b0;
        if (sts_wr_i && sts_wdata_i[STS_BIT]) begin
            flags_d.done_seen = 1'b0;
            flags_d.held      = 1'b0;
        end
        if (ctl_wr_i) begin
            if (ctl_wdata_i[MASK_BIT]) begin
                flags_d.masked = 1'b1;
            end else begin
                flags_d.masked = 1'b0;
                if (flags_d.held) begin
                    flags_d.held = 1'b0;
                    fire_d       = 1'b1;
                end
            end
        end
        if (done_i && !flags_d.done_seen) begin
            flags_d.done_seen = 1'b1;
            if (flags_d.masked) flags_d.held = 1'b1;
            else                fire_d       = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '{done_seen: 1'b0, masked: 1'b1, held: 1'b0};
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;
    assign fire_o  = fire_d;

    a_r4_held_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.held |-> flags_q.done_seen);

    a_r2_busy_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && flags_q.done_seen && !sts_wr_i && !ctl_wr_i) |=> $stable(flags_q));

    a_r5_clear_drops_both: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_i && sts_wdata_i[STS_BIT] && !done_i) |=> (!flags_q.done_seen && !flags_q.held));

endmodule

// File: rtl/inv_evt_msg.sv
module inv_evt_msg #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] data_wdata_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              fire_i,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              irq_valid_o,
    output logic [DATA_W-1:0] irq_data_o,
    output logic [ADDR_W-1:0] irq_addr_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              req;
        logic [DATA_W-1:0] req_data;
        logic [ADDR_W-1:0] req_addr;
    } msg_state_t;

    msg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = fire_i;
        if (fire_i) begin
            st_d.req_data = st_q.data;
            st_d.req_addr = st_q.addr;
        end
        if (data_wr_i) st_d.data = data_wdata_i;
        if (addr_wr_i) st_d.addr = addr_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o      = st_q.data;
    assign addr_o      = st_q.addr;
    assign irq_valid_o = st_q.req;
    assign irq_data_o  = st_q.req_data;
    assign irq_addr_o  = st_q.req_addr;

    a_r9_payload_from_regs: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (irq_data_o == $past(data_o) && irq_addr_o == $past(addr_o)));

endmodule

// File: rtl/inv_evt_ctrl.sv
module inv_evt_ctrl
    import inv_evt_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int STS_BIT  = 0,
    parameter int MASK_BIT = REG_W - 1,
    parameter int PEND_BIT = REG_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              sts_wr_i,
    input  logic [REG_W-1:0]  sts_wdata_i,
    input  logic              ctl_wr_i,
    input  logic [REG_W-1:0]  ctl_wdata_i,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] data_wdata_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    output logic [REG_W-1:0]  sts_o,
    output logic [REG_W-1:0]  ctl_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              irq_valid_o,
    output logic [DATA_W-1:0] irq_data_o,
    output logic [ADDR_W-1:0] irq_addr_o
);

    evt_flags_t flags;
    logic       fire;

    inv_evt_flags #(
        .REG_W(REG_W), .STS_BIT(STS_BIT), .MASK_BIT(MASK_BIT)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .done_i(done_i),
        .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
        .flags_o(flags), .fire_o(fire)
    );

    inv_evt_msg #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_msg (
        .clk(clk), .rst_n(rst_n),
        .data_wr_i(data_wr_i), .data_wdata_i(data_wdata_i),
        .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i),
        .fire_i(fire), .data_o(data_o), .addr_o(addr_o),
        .irq_valid_o(irq_valid_o), .irq_data_o(irq_data_o), .irq_addr_o(irq_addr_o)
    );

    always_comb begin
        sts_o           = '0;
        sts_o[STS_BIT]  = flags.done_seen;
        ctl_o           = '0;
        ctl_o[MASK_BIT] = flags.masked;
        ctl_o[PEND_BIT] = flags.held;
    end

    a_r7_no_request_while_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> !ctl_o[MASK_BIT]);

    a_r3_open_pulse_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !sts_o[STS_BIT] && !ctl_o[MASK_BIT] && !(ctl_wr_i && ctl_wdata_i[MASK_BIT]))
        |=> (irq_valid_o && sts_o[STS_BIT]));

    a_r4_masked_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !sts_o[STS_BIT] && ctl_o[MASK_BIT] && !ctl_wr_i)
        |=> (!irq_valid_o && ctl_o[PEND_BIT]));

endmodule

// File: tb/inv_evt_ctrl_tb.sv
`timescale 1ns/1ps
module inv_evt_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0, sts_wr_i = 1'b0, ctl_wr_i = 1'b0, data_wr_i = 1'b0, addr_wr_i = 1'b0;
    logic [31:0] sts_wdata_i = '0, ctl_wdata_i = '0, data_wdata_i = '0, addr_wdata_i = '0;
    logic [31:0] sts_o, ctl_o, data_o, addr_o, irq_data_o, irq_addr_o;
    logic        irq_valid_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Reference state, built from the requirements.
    bit m_sts, m_msk, m_pnd, e_fire;
    logic [31:0] m_data, m_addr, e_idata, e_iaddr;

    always #2.5 clk = ~clk;

    inv_evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i),
        .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
        .data_wr_i(data_wr_i), .data_wdata_i(data_wdata_i),
        .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i),
        .sts_o(sts_o), .ctl_o(ctl_o), .data_o(data_o), .addr_o(addr_o),
        .irq_valid_o(irq_valid_o), .irq_data_o(irq_data_o), .irq_addr_o(irq_addr_o)
    );

    function automatic logic [31:0] exp_sts();
        return {31'b0, m_sts};
    endfunction

    function automatic logic [31:0] exp_ctl();
        return {m_msk, m_pnd, 30'b0};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference update: status clear, then mask write, then pulse (R10).
    task automatic model(bit dn, bit sw, logic [31:0] sd, bit cw, logic [31:0] cd,
                         bit dw, logic [31:0] dd, bit aw, logic [31:0] ad);
        e_fire = 0;
        e_idata = m_data;
        e_iaddr = m_addr;
        if (sw && sd[0]) begin m_sts = 0; m_pnd = 0; end
        if (cw) begin
            if (cd[31]) m_msk = 1;
            else begin
                m_msk = 0;
                if (m_pnd) begin m_pnd = 0; e_fire = 1; end
            end
        end
        if (dn && !m_sts) begin
            m_sts = 1;
            if (m_msk) m_pnd = 1; else e_fire = 1;
        end
        if (dw) m_data = dd;
        if (aw) m_addr = ad;
    endtask

    task automatic step(string req, bit dn, bit sw, logic [31:0] sd, bit cw, logic [31:0] cd,
                        bit dw, logic [31:0] dd, bit aw, logic [31:0] ad);
        @(negedge clk);
        done_i = dn; sts_wr_i = sw; sts_wdata_i = sd; ctl_wr_i = cw; ctl_wdata_i = cd;
        data_wr_i = dw; data_wdata_i = dd; addr_wr_i = aw; addr_wdata_i = ad;
        model(dn, sw, sd, cw, cd, dw, dd, aw, ad);
        @(posedge clk);
        #1;
        done_i = 0; sts_wr_i = 0; ctl_wr_i = 0; data_wr_i = 0; addr_wr_i = 0;
        chk(req, "sts_o", sts_o, exp_sts());
        chk(req, "ctl_o", ctl_o, exp_ctl());
        chk(req, "irq_valid_o", {31'b0, irq_valid_o}, {31'b0, e_fire});
        if (e_fire) begin
            chk(req, "irq_data_o", irq_data_o, e_idata);
            chk(req, "irq_addr_o", irq_addr_o, e_iaddr);
        end
        chk("R11", "data_o", data_o, m_data);
        chk("R11", "addr_o", addr_o, m_addr);
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h1c0ffee5));
        m_sts = 0; m_msk = 1; m_pnd = 0; m_data = 0; m_addr = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "sts_o", sts_o, 32'h0);
        chk("R1", "ctl_o", ctl_o, 32'h8000_0000);
        chk("R1", "irq_valid_o", {31'b0, irq_valid_o}, 32'h0);
        chk("R1", "data_o", data_o, 32'h0);
        idle("R1");
        // R11: payload registers
        step("R11", 0, 0, 0, 0, 0, 1, 32'hDA7A_0001, 1, 32'hFEE0_1000);
        // R4: masked pulse becomes pending
        step("R4", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: pulse while status set is ignored
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: writes to pending and other bits ignored; mask stays set
        step("R6", 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        // R7: unmask with pending replays one request
        step("R7", 0, 0, 0, 1, 32'h4000_0000, 0, 0, 0, 0);
        idle("R7");
        // R2: unmasked pulse with status still set: nothing
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R5: bit0=0 write has no effect, bit0=1 clears
        step("R5", 0, 1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0, 0);
        step("R5", 0, 1, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
        // R3 and R9: open pulse fires with old payload while data is rewritten
        step("R9", 1, 0, 0, 0, 0, 1, 32'h1234_5678, 1, 32'hFEE0_2000);
        idle("R3");
        // R8: unmask without pending
        step("R6", 0, 0, 0, 1, 32'h8000_0000, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 1, 32'h0000_0000, 0, 0, 0, 0);
        // R10: clear and pulse in one cycle -> new event fires
        step("R10", 1, 1, 32'h1, 0, 0, 0, 0, 0, 0);
        // R10: mask, clear and pulse together -> pending, no request
        step("R10", 1, 1, 32'h1, 1, 32'h8000_0000, 0, 0, 0, 0);
        // R10: unmask and pulse with pending -> single replay
        step("R10", 1, 0, 0, 1, 32'h0, 0, 0, 0, 0);
        // Random traffic (R10 mixes all orderings)
        for (int i = 0; i < 3000; i++) begin
            bit dn = ($urandom % 3) == 0;
            bit sw = ($urandom % 5) == 0;
            bit cw = ($urandom % 6) == 0;
            bit dw = ($urandom % 8) == 0;
            bit aw = ($urandom % 8) == 0;
            step("R10", dn, sw, $urandom, cw, $urandom, dw, $urandom, aw, $urandom);
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule